// File: doc/BRIEF.md
# Bus Trace Sample Packer

This block stores captured bus samples in a line-organised trace memory. Each accepted strobe carries two filter bits that pick a sample type. A short sample keeps only the address/control bundle. Several short samples share one memory line, each in its own tagged slot. A long sample keeps the bundle together with a full 256-bit data word, and it always takes a line of its own. When a long sample arrives while a line of short samples is only partly filled, the empty slots of that line stay marked unused and the long sample goes to the next line.

A usage counter counts the lines opened since the last clear. When the final line of the buffer has been completed, the block freezes and ignores further strobes until a restart or a reset. A clear-usage request can restart the count during a capture, so that the buffer fills only after the most recent clear. A registered read port returns any line for inspection.

Top module: `trc_packer`

## Requirements
- R1: After a synchronous reset, `frozen` is 0, `usage` is 0, and the next sample is written to line 0, slot 0.
- R2: A short sample (strobe with `flt_short`=1 and `flt_long`=0) fills the next free slot of the current line. Slot k occupies line bits [k*(BW+1) +: BW+1] as {valid=1, bundle}, and line bit LINE_W-1 (the type bit) is 0. Once all SLOTS slots are used, the next short sample opens the following line.
- R3: A long sample (strobe with `flt_long`=1) writes a whole line. The type bit is 1, bits [DW-1:0] hold the data word, bits [DW+BW-1:DW] hold the bundle, and all other bits are 0. The next sample starts a fresh line.
- R4: When a long sample follows a partly filled short line, the unfilled slots of that line keep valid=0 and zero content, and the long sample is written to the following line.
- R5: A strobe with both filter bits set stores a long sample. A strobe with neither bit set stores nothing and leaves `usage` unchanged.
- R6: `usage` counts the lines opened by accepted samples and never exceeds LINES. `frozen` rises one edge after the accepted sample that completes a line while `usage` equals LINES.
- R7: While `frozen` is 1, strobes and clear-usage requests are ignored. Memory contents and `usage` do not change.
- R8: A clear-usage request that comes with an accepted sample sets `usage` to 1, so the line holding that sample counts and LINES-1 further lines fill before the freeze. A clear-usage request without a sample sets `usage` to 0.
- R9: A restart clears `frozen` and `usage`, closes any partly filled line, and drops a strobe in the same cycle. The write position wraps modulo LINES.
- R10: `rd_line` shows the memory line at `rd_addr` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe |
| flt_short | input | 1 | Filter bit requesting a short sample |
| flt_long | input | 1 | Filter bit requesting a long sample |
| smp_bundle | input | BW | Captured address/control bundle |
| smp_data | input | DW | Captured data word |
| clr_use | input | 1 | Clear-usage request |
| restart | input | 1 | Leave freeze and restart the fill count |
| rd_addr | input | $clog2(LINES) | Read line address |
| rd_line | output | LINE_W | Registered read data |
| usage | output | $clog2(LINES+1) | Lines opened since the last clear |
| frozen | output | 1 | Buffer full, strobes ignored |

## Verification
A strobe presented before a rising edge is written to memory on that edge, and `usage` and `frozen` change on the same edge. A line can therefore be read back by applying its address one edge later, and `rd_line` is valid after the following edge. The bench drives inputs at falling edges and compares status at the next falling edge. For a line check, it holds the read address across one rising edge before sampling, so each comparison falls in the first cycle the result is due. The expected lines come from an arithmetic slot/line model that the bench advances once per driven cycle.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_SHORT = 2'd1,
        KIND_LONG  = 2'd2
    } smp_kind_e;

    typedef struct packed {
        logic      en;
        smp_kind_e kind;
        logic      fresh;
    } wr_ctl_t;

    localparam logic LINE_IS_SHORT = 1'b0;
    localparam logic LINE_IS_LONG  = 1'b1;

    function automatic smp_kind_e pick_kind(input logic stb, input logic fs, input logic fl);
        if (!stb)      return KIND_NONE;
        else if (fl)   return KIND_LONG;
        else if (fs)   return KIND_SHORT;
        else           return KIND_NONE;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trc_fill_ctrl.sv
module trc_fill_ctrl
    import trc_pkg::*;
#(
    parameter int LINES = 256,
    parameter int SLOTS = 3,
    localparam int PTR_W  = $clog2(LINES),
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  smp_kind_e         kind,
    input  logic              clr_use,
    input  logic              restart,
    output wr_ctl_t           wctl,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [CNT_W-1:0]  usage,
    output logic              frozen
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(LINES);
    localparam logic [PTR_W-1:0]  PTR_ONE   = PTR_W'(1);

    logic [PTR_W-1:0]  ptr_q, ptr_d, tgt;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [CNT_W-1:0]  use_q, use_d;
    logic              frz_q, frz_d;
    logic              take, opens;

    always_comb begin
        ptr_d  = ptr_q;
        slot_d = slot_q;
        use_d  = use_q;
        frz_d  = frz_q;
        tgt    = ptr_q;
        take   = 1'b0;
        opens  = 1'b0;
        if (restart) begin
            frz_d  = 1'b0;
            use_d  = '0;
            slot_d = '0;
            if (slot_q != '0) ptr_d = ptr_q + PTR_ONE;
        end else if (!frz_q) begin
            take = (kind != KIND_NONE);
            if (kind == KIND_LONG) begin
                tgt    = (slot_q != '0) ? ptr_q + PTR_ONE : ptr_q;
                ptr_d  = tgt + PTR_ONE;
                slot_d = '0;
                opens  = 1'b1;
            end else if (kind == KIND_SHORT) begin
                opens = (slot_q == '0);
                if (slot_q == LAST_SLOT) begin
                    slot_d = '0;
                    ptr_d  = ptr_q + PTR_ONE;
                end else begin
                    slot_d = slot_q + SLOT_W'(1);
                end
            end
            if (clr_use) begin
                use_d = take ? CNT_W'(1) : '0;
            end else if (opens && (use_q != CNT_FULL)) begin
                use_d = use_q + CNT_W'(1);
            end
            if (take && (use_d == CNT_FULL) && (slot_d == '0)) frz_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            slot_q <= '0;
            use_q  <= '0;
            frz_q  <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            slot_q <= slot_d;
            use_q  <= use_d;
            frz_q  <= frz_d;
        end
    end

    always_comb begin
        wctl.en    = take;
        wctl.kind  = take ? kind : KIND_NONE;
        wctl.fresh = opens;
    end

    assign wr_addr = tgt;
    assign wr_slot = slot_q;
    assign usage   = use_q;
    assign frozen  = frz_q;

endmodule

// File: rtl/trc_line_build.sv
module trc_line_build
    import trc_pkg::*;
#(
    parameter int SLOTS = 3,
    parameter int BW    = 64,
    parameter int DW    = 256,
    localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int SLOT_FW = BW + 1,
    localparam int SHORT_W = SLOTS * SLOT_FW,
    localparam int LONG_W  = BW + DW,
    localparam int PAY_W   = max_u(SHORT_W, LONG_W),
    localparam int LINE_W  = PAY_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_ctl_t           wctl,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [BW-1:0]     bundle,
    input  logic [DW-1:0]     data,
    output logic [LINE_W-1:0] wr_line
);

    logic [SHORT_W-1:0] sh_q, sh_n;
    logic               is_short;

    assign is_short = wctl.en && (wctl.kind == KIND_SHORT);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic hit;
        assign hit = is_short && (wr_slot == SLOT_W'(k));
        assign sh_n[k*SLOT_FW +: SLOT_FW] =
            hit         ? {1'b1, bundle} :
            wctl.fresh  ? '0 :
                          sh_q[k*SLOT_FW +: SLOT_FW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (is_short) begin
            sh_q <= sh_n;
        end
    end

    always_comb begin
        logic [PAY_W-1:0] pay;
        pay = '0;
        if (wctl.kind == KIND_LONG) begin
            pay[LONG_W-1:0] = {bundle, data};
            wr_line = {LINE_IS_LONG, pay};
        end else begin
            pay[SHORT_W-1:0] = sh_n;
            wr_line = {LINE_IS_SHORT, pay};
        end
    end

endmodule

// File: rtl/trc_line_mem.sv
module trc_line_mem #(
    parameter int LINES  = 256,
    parameter int LINE_W = 321,
    localparam int PTR_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [LINE_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [LINE_W-1:0] rdata
);

    logic [LINE_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/trc_packer.sv
module trc_packer
    import trc_pkg::*;
#(
    parameter int LINES = 256,
    parameter int SLOTS = 3,
    parameter int BW    = 64,
    parameter int DW    = 256,
    localparam int PTR_W  = $clog2(LINES),
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W  = $clog2(LINES + 1),
    localparam int PAY_W  = max_u(SLOTS * (BW + 1), BW + DW),
    localparam int LINE_W = PAY_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic              flt_short,
    input  logic              flt_long,
    input  logic [BW-1:0]     smp_bundle,
    input  logic [DW-1:0]     smp_data,
    input  logic              clr_use,
    input  logic              restart,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [LINE_W-1:0] rd_line,
    output logic [CNT_W-1:0]  usage,
    output logic              frozen
);

    smp_kind_e         kind;
    wr_ctl_t           wctl;
    logic [PTR_W-1:0]  wr_addr;
    logic [SLOT_W-1:0] wr_slot;
    logic [LINE_W-1:0] wr_line;
    logic              wr_en;

    assign kind  = pick_kind(smp_stb, flt_short, flt_long);
    assign wr_en = wctl.en;

    trc_fill_ctrl #(.LINES(LINES), .SLOTS(SLOTS)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .kind    (kind),
        .clr_use (clr_use),
        .restart (restart),
        .wctl    (wctl),
        .wr_addr (wr_addr),
        .wr_slot (wr_slot),
        .usage   (usage),
        .frozen  (frozen)
    );

    trc_line_build #(.SLOTS(SLOTS), .BW(BW), .DW(DW)) u_build (
        .clk     (clk),
        .rst     (rst),
        .wctl    (wctl),
        .wr_slot (wr_slot),
        .bundle  (smp_bundle),
        .data    (smp_data),
        .wr_line (wr_line)
    );

    trc_line_mem #(.LINES(LINES), .LINE_W(LINE_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_line),
        .raddr (rd_addr),
        .rdata (rd_line)
    );

endmodule

// File: rtl/trc_packer_chk.sv
module trc_packer_chk
    import trc_pkg::*;
#(
    parameter int LINES = 256,
    localparam int CNT_W = $clog2(LINES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_stb,
    input logic             flt_long,
    input logic             clr_use,
    input logic             restart,
    input logic             wr_en,
    input smp_kind_e        wr_kind,
    input logic [CNT_W-1:0] usage,
    input logic             frozen
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LINES);

    // R1
    a_r1_reset_state: assert property (@(posedge clk) rst |=> (usage == '0) && !frozen);

    // R5
    a_r5_long_wins: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && flt_long && !frozen && !restart) |-> (wr_en && wr_kind == KIND_LONG));

    // R6
    a_r6_usage_bound: assert property (@(posedge clk) disable iff (rst) usage <= CNT_FULL);

    // R6
    a_r6_freeze_at_full: assert property (@(posedge clk) disable iff (rst)
        $rose(frozen) |-> (usage == CNT_FULL));

    // R7
    a_r7_frozen_no_write: assert property (@(posedge clk) disable iff (rst) frozen |-> !wr_en);

    // R7
    a_r7_frozen_sticky: assert property (@(posedge clk) disable iff (rst)
        (frozen && !restart) |=> (frozen && $stable(usage)));

    // R8
    a_r8_clear_with_sample: assert property (@(posedge clk) disable iff (rst)
        (clr_use && wr_en) |=> (usage == CNT_W'(1)));

    // R9
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!frozen && usage == '0));

endmodule

bind trc_packer trc_packer_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .smp_stb  (smp_stb),
    .flt_long (flt_long),
    .clr_use  (clr_use),
    .restart  (restart),
    .wr_en    (wr_en),
    .wr_kind  (wctl.kind),
    .usage    (usage),
    .frozen   (frozen)
);

// File: tb/tb_trc_packer.sv
module tb_trc_packer;

    localparam int CLK_PERIOD = 10;
    localparam int LINES  = 8;
    localparam int SLOTS  = 3;
    localparam int BW     = 8;
    localparam int DW     = 16;
    localparam int FW     = BW + 1;
    localparam int LINE_W = 1 + ((SLOTS * FW > BW + DW) ? SLOTS * FW : BW + DW);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_stb = 1'b0, flt_short = 1'b0, flt_long = 1'b0;
    logic [BW-1:0]     smp_bundle = '0;
    logic [DW-1:0]     smp_data = '0;
    logic              clr_use = 1'b0, restart = 1'b0;
    logic [2:0]        rd_addr = '0;
    logic [LINE_W-1:0] rd_line;
    logic [3:0]        usage;
    logic              frozen;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [LINE_W-1:0] m_mem [LINES];
    bit                m_wr  [LINES];
    logic [2:0]        m_ptr;
    int                m_slot, m_use;
    bit                m_frz;

    always #(CLK_PERIOD/2) clk = ~clk;

    trc_packer #(.LINES(LINES), .SLOTS(SLOTS), .BW(BW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .flt_short(flt_short), .flt_long(flt_long),
        .smp_bundle(smp_bundle), .smp_data(smp_data), .clr_use(clr_use), .restart(restart),
        .rd_addr(rd_addr), .rd_line(rd_line), .usage(usage), .frozen(frozen)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step(input bit stb, input bit fs, input bit fl, input logic [BW-1:0] b,
                              input logic [DW-1:0] d, input bit clr, input bit rs);
        bit opened;
        opened = 1'b0;
        if (rs) begin
            if (m_slot != 0) m_ptr = m_ptr + 3'd1;
            m_slot = 0; m_use = 0; m_frz = 1'b0;
            return;
        end
        if (m_frz) return;
        if (!stb || !(fs || fl)) begin
            if (clr) m_use = 0;
            return;
        end
        if (fl) begin
            if (m_slot != 0) m_ptr = m_ptr + 3'd1;
            m_mem[m_ptr] = '0;
            m_mem[m_ptr][LINE_W-1] = 1'b1;
            m_mem[m_ptr][BW+DW-1:0] = {b, d};
            m_wr[m_ptr] = 1'b1;
            m_ptr = m_ptr + 3'd1;
            m_slot = 0;
            opened = 1'b1;
        end else begin
            opened = (m_slot == 0);
            if (opened) m_mem[m_ptr] = '0;
            m_mem[m_ptr][m_slot*FW +: FW] = {1'b1, b};
            m_wr[m_ptr] = 1'b1;
            m_slot++;
            if (m_slot == SLOTS) begin m_slot = 0; m_ptr = m_ptr + 3'd1; end
        end
        if (clr) m_use = 1;
        else if (opened && m_use < LINES) m_use++;
        if (m_use == LINES && m_slot == 0) m_frz = 1'b1;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic drive(input bit stb, input bit fs, input bit fl, input logic [BW-1:0] b,
                         input logic [DW-1:0] d, input bit clr, input bit rs);
        smp_stb = stb; flt_short = fs; flt_long = fl; smp_bundle = b; smp_data = d;
        clr_use = clr; restart = rs;
        @(posedge clk);
        model_step(stb, fs, fl, b, d, clr, rs);
        @(negedge clk);
        smp_stb = 1'b0; flt_short = 1'b0; flt_long = 1'b0; clr_use = 1'b0; restart = 1'b0;
    endtask

    task automatic short_s(input logic [BW-1:0] b);
        drive(1, 1, 0, b, 16'hDEAD, 0, 0);
    endtask

    task automatic long_s(input logic [BW-1:0] b, input logic [DW-1:0] d);
        drive(1, 0, 1, b, d, 0, 0);
    endtask

    task automatic check_line(input logic [2:0] a, input string req);
        rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        chk(rd_line === m_mem[a], req, 32'(rd_line), 32'(m_mem[a]));
    endtask

    task automatic check_stat(input string req);
        chk(usage == 4'(m_use), req, 32'(usage), 32'(m_use));
        chk(frozen == m_frz, req, 32'(frozen), 32'(m_frz));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        m_ptr = '0; m_slot = 0; m_use = 0; m_frz = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_mem[i] = '0; m_wr[i] = 1'b0; end
        @(negedge clk);
        do_reset();
        check_stat("R1");

        // R1/R2: three shorts fill line 0
        short_s(8'h11); short_s(8'h22); short_s(8'h33);
        check_line(3'd0, "R2");
        check_stat("R2");
        short_s(8'h44);
        check_line(3'd1, "R2 next line");
        chk(usage == 4'd2, "R2 usage", 32'(usage), 32'd2);

        // R4/R3: long after partial line
        long_s(8'hA5, 16'h1234);
        check_line(3'd1, "R4 padded");
        check_line(3'd2, "R3 long");

        // R5: both bits, then neither bit
        drive(1, 1, 1, 8'h5A, 16'hBEEF, 0, 0);
        check_line(3'd3, "R5 both bits");
        drive(1, 0, 0, 8'h77, 16'h7777, 0, 0);
        check_stat("R5 no bits");
        short_s(8'h66);
        check_line(3'd4, "R5 no-bit strobe stored nothing");

        // R8: clear with sample, clear alone
        drive(1, 1, 0, 8'h99, 16'h0, 1, 0);
        chk(usage == 4'd1, "R8 clear with sample", 32'(usage), 32'd1);
        drive(0, 0, 0, 8'h0, 16'h0, 1, 0);
        chk(usage == 4'd0, "R8 clear alone", 32'(usage), 32'd0);

        // R4 sweep: n shorts then a long, for n = 0..7
        for (int n = 0; n < 8; n++) begin
            do_reset();
            for (int i = 0; i < n; i++) short_s(8'(n * 16 + i));
            long_s(8'(8'hC0 + n), 16'(n * 257));
            check_stat("R4 sweep status");
            for (int a = 0; a < LINES; a++)
                if (m_wr[a]) check_line(3'(a), "R4 sweep line");
        end

        // R6/R7: fill with longs after clearing the count mid-capture
        do_reset();
        for (int i = 0; i < 3; i++) long_s(8'(i), 16'(i + 100));
        drive(1, 0, 1, 8'hE0, 16'hE0E0, 1, 0);
        chk(usage == 4'd1, "R8 clear mid-capture", 32'(usage), 32'd1);
        for (int i = 0; i < LINES - 2; i++) long_s(8'(8'hE1 + i), 16'(i));
        check_stat("R6 one line before full");
        chk(frozen == 1'b0, "R6 not yet frozen", 32'(frozen), 32'd0);
        long_s(8'hEF, 16'hFFFF);
        chk(frozen == 1'b1, "R6 frozen", 32'(frozen), 32'd1);
        chk(usage == 4'(LINES), "R6 usage full", 32'(usage), 32'(LINES));
        drive(1, 1, 0, 8'h55, 16'h0, 0, 0);
        drive(1, 0, 1, 8'h56, 16'h5656, 1, 0);
        check_stat("R7 frozen ignores");
        for (int a = 0; a < LINES; a++) check_line(3'(a), "R7 memory unchanged");

        // R9: restart with a dropped strobe, then wrapped writes
        drive(1, 1, 0, 8'hBB, 16'h0, 0, 1);
        check_stat("R9 restart");
        short_s(8'hC1);
        check_line(m_ptr, "R9 wrapped short");
        drive(0, 0, 0, 8'h0, 16'h0, 0, 1);
        short_s(8'hC2);
        check_line(m_ptr, "R9 partial line closed");
        check_line(m_ptr - 3'd1, "R10 read earlier line");

        // R6 short fill: 3*LINES shorts freeze exactly at the last slot
        do_reset();
        for (int i = 0; i < SLOTS * LINES - 1; i++) short_s(8'(i));
        chk(frozen == 1'b0, "R6 short fill before", 32'(frozen), 32'd0);
        short_s(8'hFE);
        chk(frozen == 1'b1, "R6 short fill frozen", 32'(frozen), 32'd1);
        check_line(3'd7, "R6 last short line");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule